// File: doc/BRIEF.md
# DDR2 Column Command Scheduler

This block lives on the controller side of a DDR2-style memory interface. It turns read and write requests for banks that are already open into column commands on the command pins. Requests arrive through a valid/ready handshake, each carrying a column address, a direction and an optional interrupt flag. An accepted request appears on the chip-select, row-strobe, column-strobe and write-enable pins for exactly one clock cycle. On every other cycle the block drives a no-operation code.

The block keeps column commands at least the minimum CAS-to-CAS spacing apart for the configured burst length. With burst length 8 it also lets a request flagged as an interrupt cut the previous burst short after two clocks. For reads it raises a data-valid window once the read latency has passed, where read latency is the additive latency plus the CAS latency. While the window is open it reports the column address of the first beat of each clock cycle, wrapping inside the aligned burst segment.

Burst length, CAS latency and additive latency are static inputs. They are captured only while nothing is in flight.

Top module: `colsched_top`

## Requirements
- R1: After reset, and in every cycle with no column command, the pins carry the no-operation code: `ddr_cs_n`=0, `ddr_ras_n`=1, `ddr_cas_n`=1, `ddr_we_n`=1. After reset `rd_valid`=0 and `req_ready`=1.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both high) drives its command during the following cycle, with `ddr_col` equal to `req_col`. A read is cs_n=0, ras_n=1, cas_n=0, we_n=1. A write is the same except we_n=0.
- R3: With burst length 4 (`cfg_bl8`=0), `req_ready` is low in the cycle right after an accept, so column commands are at least 2 clocks apart.
- R4: With burst length 8 (`cfg_bl8`=1), a request without `req_cut` is held off for 3 cycles after an accept, so column commands are at least 4 clocks apart.
- R5: With burst length 8, a request with `req_cut`=1 in the same direction as the previous command is accepted 2 clocks after it. The earlier read window is then cut to 2 cycles, and the new burst follows without a gap.
- R6: With burst length 8, a `req_cut` request in the opposite direction to the previous command still waits the full 4-clock spacing.
- R7: For a read command driven in cycle c, `rd_valid` rises in cycle c+AL+CL, with AL=`cfg_al` and CL=`cfg_cl`. The legal ranges are CL 2..6 and AL 0..5. A write produces no `rd_valid` window.
- R8: An uninterrupted read window lasts 2 cycles with burst length 4 and 4 cycles with burst length 8.
- R9: `rd_col` gives the first beat's column for each window cycle. It starts at the requested column, and each later cycle adds 2 to the low 2 bits (burst length 4) or the low 3 bits (burst length 8), modulo the burst length. The upper bits stay fixed.
- R10: Burst-length-4 reads issued exactly 2 clocks apart produce one unbroken `rd_valid` run with no idle cycle between the bursts.
- R11: Configuration inputs are captured only while no command spacing, pending read or open window is outstanding. A change while busy does not affect the bursts in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cfg_cl | input | LAT_W | CAS latency in clocks |
| cfg_al | input | LAT_W | Additive latency in clocks |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cut | input | 1 | Request may interrupt a burst-length-8 burst |
| req_col | input | COL_W | Starting column address |
| req_ready | output | 1 | Request can be accepted this cycle |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_col | output | COL_W | Column address of the driven command |
| rd_valid | output | 1 | Read data window open |
| rd_col | output | COL_W | Column of the first beat in this window cycle |

## Verification
The read path is driven with single reads over six mixes of burst length, CAS latency, additive latency and start column. Some start columns sit at the top of their segment, which separates a correct wrap from a carry into the upper column bits, and the spread of latencies exposes any off-by-one in the start of the window. Paired commands exercise the spacing rules. Back-to-back burst-length-4 reads show whether the window joins up seamlessly. A same-direction interrupt against an opposite-direction one shows whether the cut is both granted and limited. A write shows that no read window opens. Changing the configuration mid-burst shows that it is captured only when the block is idle.

// File: rtl/colsched_pkg.sv
package colsched_pkg;

    // Command pin code {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        PINS_NOP   = 4'b0111,
        PINS_READ  = 4'b0101,
        PINS_WRITE = 4'b0100
    } pins_e;

    localparam int GAP_SHORT = 2;  // burst length 4 spacing
    localparam int GAP_LONG  = 4;  // burst length 8 spacing
    localparam int CUT_AFTER = 2;  // earliest interrupt with burst length 8

endpackage

// File: rtl/colsched_gap.sv
module colsched_gap
    import colsched_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic is_bl8,
    input  logic cut_req,
    input  logic req_write,
    output logic ready,
    output logic busy
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             last_wr;
        logic             last_bl8;
    } gap_st_t;

    gap_st_t st_d, st_q;
    logic    cut_ok;

    always_comb begin
        st_d   = st_q;
        cut_ok = st_q.last_bl8 && cut_req && (req_write == st_q.last_wr)
                 && (st_q.cnt <= CNT_W'(GAP_LONG - CUT_AFTER));
        ready  = (st_q.cnt == '0) || cut_ok;
        busy   = (st_q.cnt != '0);
        if (issue) begin
            st_d.cnt      = is_bl8 ? CNT_W'(GAP_LONG - 1) : CNT_W'(GAP_SHORT - 1);
            st_d.last_wr  = req_write;
            st_d.last_bl8 = is_bl8;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: burst length 4 blocks the very next cycle
    p_short_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !is_bl8 |=> !ready);

    // R4: burst length 8 blocks the next cycle even for an interrupt
    p_long_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue && is_bl8 |=> !ready);

    // R4: second cycle after a burst-length-8 command only opens for a cut
    p_long_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue, 2) && $past(is_bl8, 2) && !$past(issue) && !cut_req |-> !ready);

    // R6: opposite direction never interrupts
    p_cut_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cut_req && (req_write != st_q.last_wr) |-> !ready);

endmodule

// File: rtl/colsched_rdwin.sv
module colsched_rdwin #(
    parameter int COL_W = 10,
    parameter int DEPTH = 11,
    parameter int RL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [RL_W-1:0]  rl,
    input  logic             is_bl8,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col,
    output logic             empty
);

    typedef struct packed {
        logic [DEPTH-1:0]            pv;
        logic [DEPTH-1:0][COL_W-1:0] pc;
        logic                        act;
        logic [1:0]                  left;
        logic                        bl8;
        logic [COL_W-1:0]            col;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic [COL_W-1:0] mask;
    int               idx;

    always_comb begin
        st_d = st_q;
        // advance the latency line by one slot
        for (int i = 0; i < DEPTH - 1; i++) begin
            st_d.pv[i] = st_q.pv[i+1];
            st_d.pc[i] = st_q.pc[i+1];
        end
        st_d.pv[DEPTH-1] = 1'b0;
        st_d.pc[DEPTH-1] = '0;

        if (rl == '0)                          idx = 0;
        else if (int'(rl) - 1 > DEPTH - 1)     idx = DEPTH - 1;
        else                                   idx = int'(rl) - 1;

        if (start) begin
            st_d.pv[idx] = 1'b1;
            st_d.pc[idx] = start_col;
        end

        mask = st_q.bl8 ? COL_W'(7) : COL_W'(3);
        if (st_q.pv[0]) begin
            st_d.act  = 1'b1;
            st_d.left = is_bl8 ? 2'd3 : 2'd1;
            st_d.bl8  = is_bl8;
            st_d.col  = st_q.pc[0];
        end else if (st_q.act) begin
            if (st_q.left == 2'd0) begin
                st_d.act = 1'b0;
            end else begin
                st_d.left = st_q.left - 2'd1;
                st_d.col  = (st_q.col & ~mask) | ((st_q.col + COL_W'(2)) & mask);
            end
        end

        rd_valid = st_q.act;
        rd_col   = st_q.col;
        empty    = (st_q.pv == '0) && !st_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a matured entry opens the window on the next cycle
    p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pv[0] |=> rd_valid && (rd_col == $past(st_q.pc[0])));

    // R8: the last window cycle closes unless a new burst follows
    p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act && (st_q.left == 2'd0) && !st_q.pv[0] |=> !rd_valid);

    // R9: upper column bits stay put while a burst continues
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act && (st_q.left != 2'd0) && !st_q.pv[0]
        |=> rd_valid && (rd_col[COL_W-1:3] == $past(rd_col[COL_W-1:3])));

endmodule

// File: rtl/colsched_top.sv
module colsched_top
    import colsched_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int LAT_W  = 3,
    parameter int CL_MAX = 6,
    parameter int AL_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bl8,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_cut,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic             ddr_cs_n,
    output logic             ddr_ras_n,
    output logic             ddr_cas_n,
    output logic             ddr_we_n,
    output logic [COL_W-1:0] ddr_col,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col
);

    localparam int DEPTH = CL_MAX + AL_MAX;
    localparam int RL_W  = LAT_W + 1;
    localparam int CNT_W = $clog2(GAP_LONG);

    typedef struct packed {
        logic             bl8;
        logic [LAT_W-1:0] cl;
        logic [LAT_W-1:0] al;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        pins_e            pins;
        logic [COL_W-1:0] col;
    } top_st_t;

    top_st_t         st_d, st_q;
    cfg_t            cfg_eff;
    logic            gap_ready, gap_busy, win_empty, idle, issue;
    logic [RL_W-1:0] rl;

    always_comb begin
        idle      = !gap_busy && win_empty;
        cfg_eff   = idle ? '{bl8: cfg_bl8, cl: cfg_cl, al: cfg_al} : st_q.cfg;
        rl        = RL_W'(cfg_eff.cl) + RL_W'(cfg_eff.al);
        req_ready = gap_ready;
        issue     = req_valid && gap_ready;

        st_d      = st_q;
        st_d.cfg  = cfg_eff;
        st_d.pins = PINS_NOP;
        if (issue) begin
            st_d.pins = req_write ? PINS_WRITE : PINS_READ;
            st_d.col  = req_col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pins <= PINS_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = st_q.pins;
    assign ddr_col = st_q.col;

    colsched_gap #(
        .CNT_W(CNT_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .is_bl8   (cfg_eff.bl8),
        .cut_req  (req_cut),
        .req_write(req_write),
        .ready    (gap_ready),
        .busy     (gap_busy)
    );

    colsched_rdwin #(
        .COL_W(COL_W),
        .DEPTH(DEPTH),
        .RL_W (RL_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (issue && !req_write),
        .start_col(req_col),
        .rl       (rl),
        .is_bl8   (cfg_eff.bl8),
        .rd_valid (rd_valid),
        .rd_col   (rd_col),
        .empty    (win_empty)
    );

    // R1: quiet cycles carry the no-operation code
    p_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n);

    // R2: an accepted request shows as a column command with its address
    p_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !ddr_cs_n && ddr_ras_n && !ddr_cas_n
                  && (ddr_we_n == !$past(req_write)) && (ddr_col == $past(req_col)));

    // R3: two column commands never sit on adjacent cycles
    p_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cas_n |=> ddr_cas_n);

    // R11: configuration is held while anything is in flight
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> st_q.cfg == $past(st_q.cfg));

endmodule

// File: tb/colsched_top_tb.sv
module colsched_top_tb;

    localparam int COL_W = 10;
    localparam int LAT_W = 3;
    localparam int NVEC  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_bl8 = 1'b0;
    logic [LAT_W-1:0] cfg_cl = 3'd3;
    logic [LAT_W-1:0] cfg_al = 3'd0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_cut = 1'b0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_ready, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, rd_valid;
    logic [COL_W-1:0] ddr_col, rd_col;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    colsched_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bl8(cfg_bl8), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
        .req_valid(req_valid), .req_write(req_write), .req_cut(req_cut), .req_col(req_col),
        .req_ready(req_ready), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
        .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_col(ddr_col),
        .rd_valid(rd_valid), .rd_col(rd_col)
    );

    // vector: {bl8, cl, al, col}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 3'd3, 3'd0, 10'd5},
        {1'b1, 3'd3, 3'd0, 10'd3},
        {1'b0, 3'd2, 3'd0, 10'd1022},
        {1'b1, 3'd5, 3'd2, 10'd511},
        {1'b0, 3'd4, 3'd3, 10'd6},
        {1'b1, 3'd6, 3'd5, 10'd12}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int beat_col(input int col, input bit bl8, input int i);
        int m;
        m = bl8 ? 7 : 3;
        return (col & ~m) | ((col + 2 * i) & m);
    endfunction

    // present a request and wait until it is accepted; returns at the
    // falling edge of the cycle that shows the command
    task automatic send(input bit wr, input int col, input bit cut, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cut = cut; req_col = COL_W'(col);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cut = 1'b0;
        chk({req, " cas_n"}, int'(ddr_cas_n), 0);
        chk({req, " we_n"}, int'(ddr_we_n), wr ? 0 : 1);
        chk({req, " col"}, int'(ddr_col), col);
    endtask

    task automatic watch_window(input int rl, input int nb, input int col, input bit bl8);
        for (int i = 1; i <= rl + nb + 1; i++) begin
            @(negedge clk);
            chk("R7 R8 rd_valid", int'(rd_valid), (i >= rl && i < rl + nb) ? 1 : 0);
            if (i >= rl && i < rl + nb)
                chk("R9 rd_col", int'(rd_col), beat_col(col, bl8, i - rl));
        end
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 cs_n", int'(ddr_cs_n), 0);
        chk("R1 ras_n", int'(ddr_ras_n), 1);
        chk("R1 cas_n", int'(ddr_cas_n), 1);
        chk("R1 we_n", int'(ddr_we_n), 1);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 ready", int'(req_ready), 1);

        // table of single reads
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            cfg_bl8 = VEC[v][16];
            cfg_cl  = VEC[v][15:13];
            cfg_al  = VEC[v][12:10];
            send(1'b0, int'(VEC[v][9:0]), 1'b0, "R2 read");
            @(posedge clk); #1;
            chk("R1 nop after cmd", int'(ddr_cas_n), 1);
            @(negedge clk);
            // already one cycle in; watch from cycle c+2
            for (int i = 2; i <= int'(VEC[v][15:13]) + int'(VEC[v][12:10]) + 5; i++) begin
                int rl, nb;
                rl = int'(VEC[v][15:13]) + int'(VEC[v][12:10]);
                nb = VEC[v][16] ? 4 : 2;
                @(negedge clk);
                chk("R7 R8 rd_valid", int'(rd_valid), (i >= rl && i < rl + nb) ? 1 : 0);
                if (i >= rl && i < rl + nb)
                    chk("R9 rd_col", int'(rd_col), beat_col(int'(VEC[v][9:0]), VEC[v][16], i - rl));
            end
            settle();
        end

        // R7: write opens no window
        cfg_bl8 = 1'b0; cfg_cl = 3'd3; cfg_al = 3'd0;
        send(1'b1, 40, 1'b0, "R2 write");
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            chk("R7 write no window", int'(rd_valid), 0);
        end
        settle();

        // R3 R10: burst length 4 back to back
        send(1'b0, 5, 1'b0, "R10 read A");
        req_valid = 1'b1; req_write = 1'b0; req_col = 10'd8;
        #1;
        chk("R3 ready after accept", int'(req_ready), 0);
        @(negedge clk); #1;
        chk("R3 ready at gap", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 read B cas_n", int'(ddr_cas_n), 0);
        begin
            int exp_c [4] = '{5, 7, 8, 10};
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R10 continuous", int'(rd_valid), 1);
                chk("R10 rd_col", int'(rd_col), exp_c[i]);
            end
            @(negedge clk);
            chk("R10 end", int'(rd_valid), 0);
        end
        settle();

        // R4 R5: burst length 8 interrupt, same direction
        cfg_bl8 = 1'b1;
        send(1'b0, 3, 1'b0, "R5 read A");
        req_valid = 1'b1; req_write = 1'b0; req_cut = 1'b1; req_col = 10'd16;
        #1;
        chk("R4 ready after accept", int'(req_ready), 0);
        @(negedge clk); #1;
        chk("R5 cut ready", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cut = 1'b0;
        chk("R5 read B cas_n", int'(ddr_cas_n), 0);
        begin
            int exp_c [6] = '{3, 5, 16, 18, 20, 22};
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                chk("R5 window", int'(rd_valid), 1);
                chk("R5 rd_col", int'(rd_col), exp_c[i]);
            end
            @(negedge clk);
            chk("R5 end", int'(rd_valid), 0);
        end
        settle();

        // R4: plain request waits 4 clocks
        send(1'b0, 0, 1'b0, "R4 read A");
        req_valid = 1'b1; req_write = 1'b0; req_col = 10'd32;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R4 held off", int'(req_ready), 0);
            @(negedge clk);
        end
        #1;
        chk("R4 ready at 4", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        settle();

        // R6: opposite direction interrupt refused
        send(1'b0, 0, 1'b0, "R6 read A");
        req_valid = 1'b1; req_write = 1'b1; req_cut = 1'b1; req_col = 10'd64;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R6 no cut", int'(req_ready), 0);
            @(negedge clk);
        end
        #1;
        chk("R6 ready at 4", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cut = 1'b0;
        chk("R6 write we_n", int'(ddr_we_n), 0);
        settle();

        // R11: configuration changed while busy is not used
        cfg_bl8 = 1'b0; cfg_cl = 3'd3; cfg_al = 3'd0;
        send(1'b0, 0, 1'b0, "R11 read A");
        cfg_bl8 = 1'b1; cfg_cl = 3'd6;
        watch_window(3, 2, 0, 1'b0);
        settle();
        send(1'b0, 0, 1'b0, "R11 read B");
        watch_window(6, 4, 0, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule